// File: doc/BRIEF.md
# Vector Element Permute Unit

This unit rearranges the elements of two 256-bit vector source operands, called j and k, into a single result vector. It decodes a 32-bit instruction word to find the operation, the element size and the three 5-bit register indices. The result and the indices appear on registered outputs one clock after the request. There are six operations: pack-even, pack-odd, pick-even, pick-odd, interleave-low and interleave-high. Each works on 8-, 16-, 32- or 64-bit elements.

The operand width is set by `wide_i`. When it is high, the operation covers all 256 bits. When it is low, only the low 128 bits are processed and the upper 128 bits of the result are zero. Pick and interleave run separately inside each 128-bit lane. Pack pairs neighbouring elements, so it never crosses a lane boundary. In every operation, j fills the odd destination slots, or the upper half of each lane for pick. The result is formed from the source values present at the clock edge, so the destination register may be the same register as j or k.

The surrounding pipeline owns the register file and hazard handling. An instruction word that matches no encoding raises `illegal_o` in place of `res_valid_o`.

Top module: `vperm_unit`

## Requirements
- R1: Instruction bits [31:20] = 12'h751 with bits [19:15] in 01100..11111 are legal. The group in bits [19:17] selects the operation: 011 pack-even, 100 pack-odd, 101 interleave-low, 110 interleave-high, 111 pick-even. In every legal word, bits [16:15] give the element size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits.
- R2: Bits [31:20] = 12'h752 with bits [19:17] = 000 decode as pick-odd, with the size taken from bits [16:15].
- R3: Any other instruction word presented with `valid_i` gives `illegal_o`=1 and `res_valid_o`=0 on the next cycle, and leaves `res_o` and the index outputs unchanged.
- R4: Pack-even: destination element 2i+1 is j element 2i, and destination element 2i is k element 2i.
- R5: Pack-odd: destination element 2i+1 is j element 2i+1, and destination element 2i is k element 2i+1.
- R6: Pick-even and pick-odd work per 128-bit lane. With n elements per lane, the low n/2 slots of the lane take the even elements of k in order, and the high n/2 slots take the even elements of j. Pick-odd uses the odd elements in the same way.
- R7: Interleave-low works per lane. Destination slot 2e+1 takes j element e of the same lane and slot 2e takes k element e, for e < n/2.
- R8: Interleave-high is the same as interleave-low but takes source element e+n/2 of the lane.
- R9: With `wide_i`=0, result bits [255:128] are zero. Bits [127:0] are the same as for a 256-bit operation.
- R10: A legal request gives `res_valid_o`=1 on the next cycle. At the same time, `vd_o`, `vj_o` and `vk_o` carry instruction bits [4:0], [9:5] and [14:10].
- R11: A cycle without `valid_i` gives `res_valid_o`=0 and `illegal_o`=0 on the next cycle, with `res_o` held.
- R12: While `rst_n` is low, all outputs are zero, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| insn_i | input | 32 | Instruction word |
| wide_i | input | 1 | 1 = 256-bit operation, 0 = 128-bit |
| src_j | input | 256 | Source operand j |
| src_k | input | 256 | Source operand k |
| res_valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Undecodable instruction |
| res_o | output | 256 | Permuted result |
| vd_o | output | 5 | Destination register index |
| vj_o | output | 5 | j register index |
| vk_o | output | 5 | k register index |

## Verification
The bench builds the unit with its default parameters: a 128-bit lane and two lanes. This gives the full 256-bit form, in which lane independence of pick and interleave can be seen, and also the 128-bit form with upper-half zeroing. Every one of the 24 encodings runs in both widths on data whose byte values name their own position, so any misplaced element shows up. The encodings at the edges of the legal ranges are also exercised: pick-odd next to the pick-even block, and the words just outside each range.

// File: rtl/vperm_unit.sv
module vperm_unit #(
  parameter int LANE_W = 128,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid_i,
  input  logic [31:0]               insn_i,
  input  logic                      wide_i,
  input  logic [LANE_W*LANES-1:0]   src_j,
  input  logic [LANE_W*LANES-1:0]   src_k,
  output logic                      res_valid_o,
  output logic                      illegal_o,
  output logic [LANE_W*LANES-1:0]   res_o,
  output logic [4:0]                vd_o,
  output logic [4:0]                vj_o,
  output logic [4:0]                vk_o
);
  localparam int VW = LANE_W * LANES;
  localparam logic [2:0] OP_PACKEV = 3'd0, OP_PACKOD = 3'd1, OP_PICKEV = 3'd2,
                         OP_PICKOD = 3'd3, OP_ILVL = 3'd4, OP_ILVH = 3'd5;

  wire [11:0] major = insn_i[31:20];
  wire [4:0]  minor = insn_i[19:15];
  wire [1:0]  size  = minor[1:0];
  logic [2:0] op;
  logic       legal;

  always_comb begin
    legal = 1'b1;
    op    = OP_PACKEV;
    if (major == 12'h751) begin
      case (minor[4:2])
        3'b011:  op = OP_PACKEV;
        3'b100:  op = OP_PACKOD;
        3'b101:  op = OP_ILVL;
        3'b110:  op = OP_ILVH;
        3'b111:  op = OP_PICKEV;
        default: legal = 1'b0;
      endcase
    end else if (major == 12'h752 && minor[4:2] == 3'b000) begin
      op = OP_PICKOD;
    end else begin
      legal = 1'b0;
    end
  end

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int N  = LANE_W / EW;
    localparam int H  = N / 2;
    logic [VW-1:0] r;
    always_comb begin
      int od;
      od = op[0] ? 1 : 0;
      r  = '0;
      for (int l = 0; l < LANES; l++) begin
        for (int e = 0; e < H; e++) begin
          case (op[2:1])
            2'd0: begin
              r[(l*N+2*e+1)*EW +: EW] = src_j[(l*N+2*e+od)*EW +: EW];
              r[(l*N+2*e)*EW +: EW]   = src_k[(l*N+2*e+od)*EW +: EW];
            end
            2'd1: begin
              r[(l*N+e)*EW +: EW]     = src_k[(l*N+2*e+od)*EW +: EW];
              r[(l*N+H+e)*EW +: EW]   = src_j[(l*N+2*e+od)*EW +: EW];
            end
            2'd2: begin
              r[(l*N+2*e+1)*EW +: EW] = src_j[(l*N+e+od*H)*EW +: EW];
              r[(l*N+2*e)*EW +: EW]   = src_k[(l*N+e+od*H)*EW +: EW];
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic [VW-1:0] perm;
  always_comb begin
    case (size)
      2'd0:    perm = g_sz[0].r;
      2'd1:    perm = g_sz[1].r;
      2'd2:    perm = g_sz[2].r;
      default: perm = g_sz[3].r;
    endcase
  end

  wire [VW-1:0] nxt = wide_i ? perm : {{(VW-LANE_W){1'b0}}, perm[LANE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      res_o       <= '0;
      vd_o        <= '0;
      vj_o        <= '0;
      vk_o        <= '0;
    end else begin
      res_valid_o <= valid_i && legal;
      illegal_o   <= valid_i && !legal;
      if (valid_i && legal) begin
        res_o <= nxt;
        vd_o  <= insn_i[4:0];
        vj_o  <= insn_i[9:5];
        vk_o  <= insn_i[14:10];
      end
    end
  end
endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk #(
  parameter int VW     = 256,
  parameter int LANE_W = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic [31:0]   insn_i,
  input logic          wide_i,
  input logic          res_valid_o,
  input logic          illegal_o,
  input logic [VW-1:0] res_o,
  input logic [4:0]    vd_o
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid_o && illegal_o));
  p_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (res_valid_o || illegal_o));
  p_dest_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (!res_valid_o || vd_o == $past(insn_i[4:0])));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!res_valid_o && !illegal_o && $stable(res_o)));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !wide_i) |=> (!res_valid_o || res_o[VW-1:LANE_W] == '0));
  p_pickod_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[31:17] == 15'b0111_0101_0010_000) |=> res_valid_o);
  p_bad_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[31:20] == 12'h752 && insn_i[19:17] != 3'b000) |=> (illegal_o && $stable(res_o)));
endmodule

bind vperm_unit vperm_unit_chk #(.VW(LANE_W*LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i), .wide_i(wide_i),
  .res_valid_o(res_valid_o), .illegal_o(illegal_o), .res_o(res_o), .vd_o(vd_o)
);

// File: tb/vperm_unit_test.sv
module vperm_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic wide_i = 1'b0;
  logic [255:0] src_j = '0, src_k = '0;
  logic res_valid_o, illegal_o;
  logic [255:0] res_o;
  logic [4:0] vd_o, vj_o, vk_o;

  vperm_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i), .wide_i(wide_i),
    .src_j(src_j), .src_k(src_k), .res_valid_o(res_valid_o), .illegal_o(illegal_o),
    .res_o(res_o), .vd_o(vd_o), .vj_o(vj_o), .vk_o(vk_o)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic e_v = 0, e_ill = 0;
  logic [255:0] e_res = '0;
  logic [4:0] e_vd = 0, e_vj = 0, e_vk = 0;
  string e_tag = "R12";
  bit e_half = 0;

  task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // op: 0 pack-even, 1 pack-odd, 2 pick-even, 3 pick-odd, 4 interleave-low, 5 interleave-high; -1 illegal
  function automatic int decode(logic [31:0] w);
    logic [4:0] sub = w[19:15];
    if (w[31:20] == 12'h752) return (sub <= 5'b00011) ? 3 : -1;
    if (w[31:20] != 12'h751) return -1;
    if (sub >= 5'b11100) return 2;
    if (sub >= 5'b11000) return 5;
    if (sub >= 5'b10100) return 4;
    if (sub >= 5'b10000) return 1;
    if (sub >= 5'b01100) return 0;
    return -1;
  endfunction

  function automatic string op_req(int op);
    case (op)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [255:0] model(int op, int sz, bit full, logic [255:0] a, logic [255:0] b);
    logic [255:0] out = '0;
    int eb = 1 << sz;
    int n = 16 / eb;
    int h = n / 2;
    int tot = (full ? 32 : 16) / eb;
    for (int d = 0; d < tot; d++) begin
      int l = d / n, p = d % n, s;
      bit fromj;
      case (op)
        0, 1: begin fromj = (p % 2 == 1); s = d - (p % 2) + op; end
        2, 3: begin fromj = (p >= h); s = l*n + 2*(p % h) + (op - 2); end
        default: begin fromj = (p % 2 == 1); s = l*n + p/2 + (op - 4)*h; end
      endcase
      for (int bt = 0; bt < eb; bt++)
        out[(d*eb+bt)*8 +: 8] = fromj ? a[(s*eb+bt)*8 +: 8] : b[(s*eb+bt)*8 +: 8];
    end
    return out;
  endfunction

  task automatic step(bit v, logic [31:0] w, bit f, logic [255:0] a, logic [255:0] b);
    int op;
    valid_i = v; insn_i = w; wide_i = f; src_j = a; src_k = b;
    @(posedge clk);
    op = decode(w);
    e_half = 0;
    if (!rst_n) begin
      e_v = 0; e_ill = 0; e_res = '0; e_vd = 0; e_vj = 0; e_vk = 0; e_tag = "R12";
    end else if (!v) begin
      e_v = 0; e_ill = 0; e_tag = "R11";
    end else if (op < 0) begin
      e_v = 0; e_ill = 1; e_tag = "R3";
    end else begin
      e_v = 1; e_ill = 0;
      e_res = model(op, int'(w[16:15]), f, a, b);
      e_vd = w[4:0]; e_vj = w[9:5]; e_vk = w[14:10];
      e_tag = op_req(op);
      e_half = !f;
    end
    @(negedge clk);
    chk(res_valid_o == e_v, (e_tag == "R3" || e_tag == "R11" || e_tag == "R12") ? e_tag : "R10",
        "valid", 256'(res_valid_o), 256'(e_v));
    chk(illegal_o == e_ill, (e_ill || e_tag == "R12") ? e_tag : "R1", "illegal", 256'(illegal_o), 256'(e_ill));
    chk(res_o == e_res, e_tag, "result", res_o, e_res);
    chk({vd_o, vj_o, vk_o} == {e_vd, e_vj, e_vk}, (e_tag == "R12") ? "R12" : "R10", "indices",
        256'({vd_o, vj_o, vk_o}), 256'({e_vd, e_vj, e_vk}));
    if (e_half) chk(res_o[255:128] == '0, "R9", "upper half", res_o, e_res);
  endtask

  function automatic logic [31:0] enc(int idx, logic [14:0] regs);
    logic [11:0] maj = (idx < 20) ? 12'h751 : 12'h752;
    logic [4:0] sub = (idx < 20) ? 5'(12 + idx) : 5'(idx - 20);
    return {maj, sub, regs};
  endfunction

  logic [255:0] pj, pk;

  initial begin
    for (int i = 0; i < 32; i++) begin
      pj[i*8 +: 8] = 8'(i);
      pk[i*8 +: 8] = 8'(8'h80 + i);
    end
    // R12: reset holds outputs at zero despite a legal request
    step(1, enc(0, 15'h1234), 1, pj, pk);
    step(1, enc(5, 15'h0421), 0, pj, pk);
    rst_n = 1;
    // R1 R2 R4-R10: every encoding in both widths on positional data
    for (int m = 0; m < 2; m++)
      for (int idx = 0; idx < 24; idx++) begin
        step(1, enc(idx, 15'((idx * 1093 + m * 77) & 16'h7fff)), m[0], pj, pk);
        step(1, enc(idx, 15'(idx * 311)), m[0], {pk[127:0], pk[255:128]}, ~pj);
      end
    // R3: words just outside the legal ranges leave state held
    step(1, {12'h751, 5'b01011, 15'h0063}, 1, pk, pj);
    step(1, {12'h752, 5'b00100, 15'h0063}, 1, pk, pj);
    step(1, {12'h750, 5'b11111, 15'h0063}, 1, pk, pj);
    step(1, {12'h753, 5'b01100, 15'h0063}, 0, pk, pj);
    // R11: idle cycles hold the result
    step(0, enc(3, 15'h7fff), 1, ~pk, ~pj);
    step(0, 32'h0, 0, '0, '1);
    // R6 R7 R8 R9: random data, mixed legal, illegal and idle requests
    for (int t = 0; t < 3000; t++) begin
      logic [255:0] a, b;
      logic [31:0] w;
      for (int q = 0; q < 8; q++) begin
        a[q*32 +: 32] = $urandom;
        b[q*32 +: 32] = $urandom;
      end
      w = ($urandom_range(0, 7) == 0) ? 32'($urandom) : enc($urandom_range(0, 23), 15'($urandom));
      step($urandom_range(0, 9) != 0, w, 1'($urandom), a, b);
    end
    // R12: reset mid-run clears the outputs
    rst_n = 0;
    step(1, enc(7, 15'h2aaa), 1, pj, pk);
    rst_n = 1;
    step(1, enc(23, 15'h5555), 1, pj, pk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule